// File: doc/BRIEF.md
# Execute Stage with Operand Forwarding

This block is the execute stage of a small 32-bit in-order pipeline. Each cycle it can take one instruction word from the decode stage, together with that instruction's program counter and the two register values read for it: one from the base-register field and one from the data-register or source-register field. It handles four kinds of work: a register-to-register move, an unconditional branch, a branch that also produces a return address, and load or store with a base register and no offset. Every result is registered, so the outputs for an instruction appear one clock after it is accepted.

The register values from decode may be stale. Two newer copies can exist. One is the result this stage itself produced one cycle ago. The other is a value offered by the memory stage through a forwarding bundle. For each source field, the stage picks the newest copy. A branch redirects fetch and flushes younger work. Its own forwarding entry is then dropped, so the instruction behind a branch never picks up the return address through the bypass.

Top module: `exec_stage`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release with no instruction issued, `ready`, `wb_en`, `redirect`, `flush`, `st_en` and `ld_req` are all low.
- R2: `ready` is high in the cycle after `en` was high and low in the cycle after `en` was low. An instruction presented with `en` low raises none of `wb_en`, `redirect`, `flush`, `st_en` or `ld_req`.
- R3: A word with bits 27:25 = 101 and bit 24 = 0 is a branch. One cycle later `redirect` and `flush` are both high, `wb_en` is low, and `target` equals `pc_in` plus the sign-extended bits 23:0 shifted left by two (modulo 2^32). `pc_in` is already 8 bytes ahead of the instruction.
- R4: A word with bits 27:25 = 101 and bit 24 = 1 is a branch with link. It behaves as in R3 and, in addition, drives `wb_en` high with `wb_idx` = 14 and `result` = `pc_in` − 4.
- R5: A word with bits 27:26 = 00, bit 25 = 0 and bits 24:21 = 1101 is a move. One cycle later `wb_en` is high, `wb_idx` equals bits 15:12, `result` equals the resolved value of the register named by bits 3:0, and `st_en`, `ld_req` and `redirect` are low.
- R6: A word with bits 27:26 = 01 is a memory access. With bit 20 = 0 it is a store: `st_en` is high, `st_data` is the resolved value of the register named by bits 15:12, and `mem_addr` is the resolved value of the register named by bits 19:16. With bit 20 = 1 it is a load: `ld_req` is high and `mem_addr` is formed in the same way. Neither kind raises `wb_en`.
- R7: When `fwd_valid` is high and `fwd_idx` equals a source field, that source resolves to `fwd_data` instead of the decode-stage value.
- R8: When the instruction accepted in the previous cycle raised `wb_en` without `redirect`, and its `wb_idx` equals a source field, that source resolves to its `result`. This takes priority over the memory-stage bundle.
- R9: After a branch, a branch with link, or a cycle with `en` low, no value is forwarded from this stage's own previous result.
- R10: An accepted word that matches none of the encodings above raises `ready` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| en | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| pc_in | input | XLEN | Program counter of the instruction plus 8 |
| rn_val | input | XLEN | Decode-stage value of the base register (bits 19:16) |
| rdm_val | input | XLEN | Decode-stage value of the data register (store) or source register (move) |
| fwd_valid | input | 1 | Memory-stage forwarding bundle is valid |
| fwd_idx | input | 4 | Destination register of the memory-stage bundle |
| fwd_data | input | XLEN | Value of the memory-stage bundle |
| ready | output | 1 | An instruction was accepted in the previous cycle |
| result | output | XLEN | Writeback value |
| wb_en | output | 1 | Register writeback request |
| wb_idx | output | 4 | Writeback register index |
| redirect | output | 1 | Fetch must continue at `target` |
| flush | output | 1 | Discard younger instructions |
| target | output | XLEN | Branch target |
| st_en | output | 1 | Memory write request |
| st_data | output | XLEN | Store data |
| ld_req | output | 1 | Memory read request |
| mem_addr | output | XLEN | Memory address for load or store |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 24-bit branch offset and a link distance of 4. At that width, branch offsets with the sign bit set wrap the target below the program counter, and a program counter near zero wraps the link value. Register fields are drawn from a small pool, so the own-result and memory-stage bypasses often hit the same index at once, and the priority between them is tested on many cycles. Branches and idle cycles are mixed into the stream so that dropping the own-result entry is exercised right behind each of them.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam int unsigned IDX_W    = 4;
  localparam int unsigned LINK_IDX = 14;
  localparam int unsigned IWORD_W  = 32;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_MOV,
    OP_LDR,
    OP_STR,
    OP_B,
    OP_BL
  } op_e;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
#(
  parameter int unsigned OFF_W = 24
) (
  input  logic [IWORD_W-1:0] instr,
  output op_e                op,
  output logic [IDX_W-1:0]   idx_rn,
  output logic [IDX_W-1:0]   idx_rd,
  output logic [IDX_W-1:0]   idx_rm,
  output logic [OFF_W-1:0]   offset
);

  always_comb begin
    op = OP_NONE;
    if (instr[27:25] == 3'b101) begin
      op = instr[24] ? OP_BL : OP_B;
    end else if (instr[27:26] == 2'b01) begin
      op = instr[20] ? OP_LDR : OP_STR;
    end else if (instr[27:25] == 3'b000 && instr[24:21] == 4'b1101) begin
      op = OP_MOV;
    end
  end

  assign idx_rn = instr[19:16];
  assign idx_rd = instr[15:12];
  assign idx_rm = instr[3:0];
  assign offset = instr[OFF_W-1:0];

endmodule

// File: rtl/exec_opsel.sv
module exec_opsel
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [XLEN-1:0]  rf_val,
  input  logic             own_vld,
  input  logic [IDX_W-1:0] own_idx,
  input  logic [XLEN-1:0]  own_val,
  input  logic             mem_vld,
  input  logic [IDX_W-1:0] mem_idx,
  input  logic [XLEN-1:0]  mem_val,
  output logic [XLEN-1:0]  val
);

  logic hit_own;
  logic hit_mem;

  assign hit_own = own_vld && (own_idx == src_idx);
  assign hit_mem = mem_vld && (mem_idx == src_idx);

  // The newer copy wins: own previous result, then memory stage, then file.
  always_comb begin
    if (hit_own)      val = own_val;
    else if (hit_mem) val = mem_val;
    else              val = rf_val;
  end

endmodule

// File: rtl/exec_branch.sv
module exec_branch #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned OFF_W     = 24,
  parameter int unsigned SHIFT     = 2,
  parameter int unsigned LINK_BACK = 4
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  link
);

  localparam int unsigned EXT_W = XLEN - OFF_W - SHIFT;

  logic [XLEN-1:0] disp;

  assign disp   = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
  assign target = pc + disp;
  assign link   = pc - XLEN'(LINK_BACK);

endmodule

// File: rtl/exec_stage.sv
module exec_stage
  import exec_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned OFF_W     = 24,
  parameter int unsigned SHIFT     = 2,
  parameter int unsigned LINK_BACK = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [IWORD_W-1:0]  instr,
  input  logic [XLEN-1:0]     pc_in,
  input  logic [XLEN-1:0]     rn_val,
  input  logic [XLEN-1:0]     rdm_val,
  input  logic                fwd_valid,
  input  logic [IDX_W-1:0]    fwd_idx,
  input  logic [XLEN-1:0]     fwd_data,
  output logic                ready,
  output logic [XLEN-1:0]     result,
  output logic                wb_en,
  output logic [IDX_W-1:0]    wb_idx,
  output logic                redirect,
  output logic                flush,
  output logic [XLEN-1:0]     target,
  output logic                st_en,
  output logic [XLEN-1:0]     st_data,
  output logic                ld_req,
  output logic [XLEN-1:0]     mem_addr
);

  localparam int unsigned NSRC = 3;
  localparam int unsigned S_RN = 0;
  localparam int unsigned S_RD = 1;
  localparam int unsigned S_RM = 2;

  op_e             op;
  logic [IDX_W-1:0] idx_rn, idx_rd, idx_rm;
  logic [OFF_W-1:0] offset;
  logic [XLEN-1:0]  br_target, br_link;

  logic [IDX_W-1:0] src_idx [NSRC];
  logic [XLEN-1:0]  src_rf  [NSRC];
  logic [XLEN-1:0]  src_val [NSRC];

  // Registered state
  logic             ready_q, wb_q, redir_q, st_q, ld_q;
  logic [IDX_W-1:0] wbidx_q;
  logic [XLEN-1:0]  res_q, tgt_q, sdata_q, addr_q;

  // Next state
  logic             ready_d, wb_d, redir_d, st_d, ld_d;
  logic [IDX_W-1:0] wbidx_d;
  logic [XLEN-1:0]  res_d, tgt_d, sdata_d, addr_d;

  logic             own_vld;

  exec_decode #(.OFF_W(OFF_W)) u_dec (
    .instr  (instr),
    .op     (op),
    .idx_rn (idx_rn),
    .idx_rd (idx_rd),
    .idx_rm (idx_rm),
    .offset (offset)
  );

  exec_branch #(
    .XLEN(XLEN), .OFF_W(OFF_W), .SHIFT(SHIFT), .LINK_BACK(LINK_BACK)
  ) u_br (
    .pc     (pc_in),
    .offset (offset),
    .target (br_target),
    .link   (br_link)
  );

  // Own result is a valid bypass only if it was a plain writeback.
  assign own_vld = wb_q && !redir_q;

  assign src_idx[S_RN] = idx_rn;
  assign src_idx[S_RD] = idx_rd;
  assign src_idx[S_RM] = idx_rm;
  assign src_rf[S_RN]  = rn_val;
  assign src_rf[S_RD]  = rdm_val;
  assign src_rf[S_RM]  = rdm_val;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    exec_opsel #(.XLEN(XLEN)) u_sel (
      .src_idx (src_idx[s]),
      .rf_val  (src_rf[s]),
      .own_vld (own_vld),
      .own_idx (wbidx_q),
      .own_val (res_q),
      .mem_vld (fwd_valid),
      .mem_idx (fwd_idx),
      .mem_val (fwd_data),
      .val     (src_val[s])
    );
  end

  always_comb begin
    ready_d = en;
    wb_d    = 1'b0;
    redir_d = 1'b0;
    st_d    = 1'b0;
    ld_d    = 1'b0;
    wbidx_d = wbidx_q;
    res_d   = res_q;
    tgt_d   = tgt_q;
    sdata_d = sdata_q;
    addr_d  = addr_q;
    if (en) begin
      unique case (op)
        OP_MOV: begin
          wb_d    = 1'b1;
          wbidx_d = idx_rd;
          res_d   = src_val[S_RM];
        end
        OP_B: begin
          redir_d = 1'b1;
          tgt_d   = br_target;
        end
        OP_BL: begin
          redir_d = 1'b1;
          tgt_d   = br_target;
          wb_d    = 1'b1;
          wbidx_d = IDX_W'(LINK_IDX);
          res_d   = br_link;
        end
        OP_STR: begin
          st_d    = 1'b1;
          sdata_d = src_val[S_RD];
          addr_d  = src_val[S_RN];
        end
        OP_LDR: begin
          ld_d    = 1'b1;
          addr_d  = src_val[S_RN];
        end
        default: ;
      endcase
    end
  end

  // Control registers: reset to idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      wb_q    <= 1'b0;
      redir_q <= 1'b0;
      st_q    <= 1'b0;
      ld_q    <= 1'b0;
    end else begin
      ready_q <= ready_d;
      wb_q    <= wb_d;
      redir_q <= redir_d;
      st_q    <= st_d;
      ld_q    <= ld_d;
    end
  end

  // Datapath registers: no reset, loaded only when an instruction is taken.
  always_ff @(posedge clk) begin
    if (en) begin
      wbidx_q <= wbidx_d;
      res_q   <= res_d;
      tgt_q   <= tgt_d;
      sdata_q <= sdata_d;
      addr_q  <= addr_d;
    end
  end

  assign ready    = ready_q;
  assign result   = res_q;
  assign wb_en    = wb_q;
  assign wb_idx   = wbidx_q;
  assign redirect = redir_q;
  assign flush    = redir_q;
  assign target   = tgt_q;
  assign st_en    = st_q;
  assign st_data  = sdata_q;
  assign ld_req   = ld_q;
  assign mem_addr = addr_q;

endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk
  import exec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic [IWORD_W-1:0]  instr,
  input logic [XLEN-1:0]     pc_in,
  input logic                ready,
  input logic [XLEN-1:0]     result,
  input logic                wb_en,
  input logic [IDX_W-1:0]    wb_idx,
  input logic                redirect,
  input logic                flush,
  input logic                st_en,
  input logic                ld_req
);

  // R2
  ready_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ready);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !ready && !wb_en && !redirect && !st_en && !ld_req);

  // R3
  plain_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && instr[27:25] == 3'b101 && !instr[24] |=> redirect && flush && !wb_en);

  // R4
  link_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && instr[27:25] == 3'b101 && instr[24]
      |=> redirect && wb_en && wb_idx == IDX_W'(LINK_IDX)
          && result == $past(pc_in) - XLEN'(4));

  // R5
  move_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && instr[27:25] == 3'b000 && instr[24:21] == 4'b1101
      |=> wb_en && !st_en && !ld_req && !redirect);

  // R6
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> !wb_en && !ld_req && !redirect);

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !wb_en && !redirect && !st_en && !ld_req);

endmodule

bind exec_stage exec_stage_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .instr    (instr),
  .pc_in    (pc_in),
  .ready    (ready),
  .result   (result),
  .wb_en    (wb_en),
  .wb_idx   (wb_idx),
  .redirect (redirect),
  .flush    (flush),
  .st_en    (st_en),
  .ld_req   (ld_req)
);

// File: tb/exec_stage_tb.sv
`timescale 1ns/1ps
module exec_stage_tb;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            en;
  logic [31:0]     instr;
  logic [XLEN-1:0] pc_in, rn_val, rdm_val, fwd_data;
  logic            fwd_valid;
  logic [3:0]      fwd_idx;
  logic            ready, wb_en, redirect, flush, st_en, ld_req;
  logic [XLEN-1:0] result, target, st_data, mem_addr;
  logic [3:0]      wb_idx;

  exec_stage u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .instr(instr), .pc_in(pc_in),
    .rn_val(rn_val), .rdm_val(rdm_val), .fwd_valid(fwd_valid),
    .fwd_idx(fwd_idx), .fwd_data(fwd_data), .ready(ready), .result(result),
    .wb_en(wb_en), .wb_idx(wb_idx), .redirect(redirect), .flush(flush),
    .target(target), .st_en(st_en), .st_data(st_data), .ld_req(ld_req),
    .mem_addr(mem_addr)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  bit          own_v;
  int unsigned own_i;
  logic [31:0] own_d;
  bit          have_exp;
  string       tag;
  bit          e_ready, e_wb, e_redir, e_st, e_ld;
  int unsigned e_wbidx;
  logic [31:0] e_res, e_tgt, e_sdata, e_addr;

  task automatic chk(input bit ok, input string t, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  task automatic compare();
    if (!have_exp) return;
    chk(ready == e_ready, "R2", "ready", 32'(ready), 32'(e_ready));
    chk(wb_en == e_wb, tag, "wb_en", 32'(wb_en), 32'(e_wb));
    chk(redirect == e_redir, tag, "redirect", 32'(redirect), 32'(e_redir));
    chk(flush == e_redir, tag, "flush", 32'(flush), 32'(e_redir));
    chk(st_en == e_st, tag, "st_en", 32'(st_en), 32'(e_st));
    chk(ld_req == e_ld, tag, "ld_req", 32'(ld_req), 32'(e_ld));
    if (e_wb) begin
      chk(result == e_res, tag, "result", result, e_res);
      chk(32'(wb_idx) == e_wbidx, tag, "wb_idx", 32'(wb_idx), e_wbidx);
    end
    if (e_redir) chk(target == e_tgt, tag, "target", target, e_tgt);
    if (e_st)    chk(st_data == e_sdata, tag, "st_data", st_data, e_sdata);
    if (e_st || e_ld) chk(mem_addr == e_addr, tag, "mem_addr", mem_addr, e_addr);
  endtask

  // Resolve one source; upgrades tag to R8 / R7 when a bypass is taken.
  function automatic logic [31:0] pick(input int unsigned idx, input logic [31:0] rf,
                                       input bit fv, input int unsigned fi,
                                       input logic [31:0] fd, inout string t);
    if (own_v && own_i == idx) begin t = "R8"; return own_d; end
    if (fv && fi == idx) begin if (t != "R8") t = "R7"; return fd; end
    return rf;
  endfunction

  task automatic step(input bit e, input logic [31:0] w, input logic [31:0] pc,
                      input logic [31:0] rn, input logic [31:0] rdm,
                      input bit fv, input int unsigned fi, input logic [31:0] fd);
    string t;
    bit prev_inval;
    int signed off;
    @(negedge clk);
    compare();
    prev_inval = !own_v;
    en = e; instr = w; pc_in = pc; rn_val = rn; rdm_val = rdm;
    fwd_valid = fv; fwd_idx = 4'(fi); fwd_data = fd;
    e_ready = e; e_wb = 0; e_redir = 0; e_st = 0; e_ld = 0;
    t = prev_inval ? "R9" : "R10";
    if (!e) t = "R2";
    else if (w[27:25] == 3'b101) begin
      off = int'({{8{w[23]}}, w[23:0]});
      e_redir = 1;
      e_tgt = pc + 32'(off * 4);
      t = w[24] ? "R4" : "R3";
      if (w[24]) begin e_wb = 1; e_wbidx = 14; e_res = pc - 32'd4; end
    end else if (w[27:26] == 2'b01) begin
      t = "R6";
      e_addr = pick(w[19:16], rn, fv, w[19:16] == fi ? fi : fi, fd, t);
      if (w[20]) e_ld = 1;
      else begin
        e_st = 1;
        e_sdata = pick(w[15:12], rdm, fv, fi, fd, t);
      end
    end else if (w[27:25] == 3'b000 && w[24:21] == 4'b1101) begin
      t = prev_inval ? "R9" : "R5";
      e_wb = 1; e_wbidx = w[15:12];
      e_res = pick(w[3:0], rdm, fv, fi, fd, t);
    end
    tag = t;
    have_exp = 1;
    own_v = e_wb && !e_redir;
    own_i = e_wbidx;
    own_d = e_res;
  endtask

  function automatic logic [31:0] mk_mov(input int unsigned rd, input int unsigned rm);
    return 32'he1a00000 | (32'(rd) << 12) | 32'(rm);
  endfunction
  function automatic logic [31:0] mk_mem(input bit ld, input int unsigned rn, input int unsigned rd);
    return 32'he5800000 | (ld ? 32'h0010_0000 : 0) | (32'(rn) << 16) | (32'(rd) << 12);
  endfunction
  function automatic logic [31:0] mk_br(input bit lnk, input logic [23:0] o);
    return (lnk ? 32'heb000000 : 32'hea000000) | 32'(o);
  endfunction

  function automatic int unsigned rr();
    int unsigned p;
    p = $urandom_range(0, 5);
    return (p == 5) ? 14 : p;
  endfunction

  initial begin
    #150000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1;
  end

  initial begin : main
    rst_n = 0; en = 0; instr = 0; pc_in = 0; rn_val = 0; rdm_val = 0;
    fwd_valid = 0; fwd_idx = 0; fwd_data = 0;
    own_v = 0; own_i = 0; own_d = 0; have_exp = 0; tag = "R1";
    repeat (3) @(negedge clk);
    // R1: idle while held in reset
    chk(!ready && !wb_en && !redirect && !flush && !st_en && !ld_req, "R1",
        "flags in reset", {26'd0, ready, wb_en, redirect, flush, st_en, ld_req}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!ready && !wb_en && !redirect && !st_en && !ld_req, "R1",
        "flags after release", {27'd0, ready, wb_en, redirect, st_en, ld_req}, 32'd0);

    // Own forward: move then store of the moved register
    step(1, mk_mov(5, 4), 32'h100, 32'h2a, 32'hdeadbeef, 0, 0, 0);
    step(1, mk_mem(0, 8, 5), 32'h104, 32'h1, 32'hbabafafa, 0, 0, 0);
    // Memory-stage forward into a move, then own forward back
    step(1, mk_mov(5, 4), 32'h108, 32'h2a, 32'hdeadbeef, 1, 4, 32'hbabafafa);
    step(1, mk_mov(4, 5), 32'h10c, 32'h2a, 32'h11111111, 0, 0, 0);
    // Both sources match r4: own must win (R8)
    step(1, mk_mov(4, 4), 32'h110, 0, 32'h22222222, 1, 4, 32'h33333333);
    // Load with forwarded base
    step(1, mk_mem(1, 4, 0), 32'h114, 32'h44, 0, 1, 4, 32'h55);
    // Plain branch with negative offset, then link branch near zero
    step(1, mk_br(0, 24'hfffffa), 32'h1c, 0, 0, 0, 0, 0);
    step(1, mk_br(1, 24'hfffffb), 32'h2, 0, 0, 0, 0, 0);
    // Behind the link branch, r14 must come from the register file (R9)
    step(1, mk_mov(3, 14), 32'h30, 0, 32'h77, 0, 0, 0);
    // Bubble breaks the own bypass
    step(0, mk_mov(3, 3), 32'h34, 0, 32'h88, 0, 0, 0);
    step(1, mk_mov(2, 3), 32'h38, 0, 32'h99, 0, 0, 0);
    // Unknown word raises ready only (R10)
    step(1, 32'he0810002, 32'h3c, 0, 0, 0, 0, 0);
    step(1, mk_br(0, 24'h7fffff), 32'hfffffff0, 0, 0, 0, 0, 0);

    for (int n = 0; n < 2000; n++) begin
      logic [31:0] w;
      int unsigned k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2, 3: w = mk_mov(rr(), rr());
        4, 5:       w = mk_mem(0, rr(), rr());
        6:          w = mk_mem(1, rr(), rr());
        7:          w = mk_br($urandom_range(0, 1) == 1, 24'($urandom));
        8:          w = 32'he0810002;
        default:    w = mk_mov(rr(), rr());
      endcase
      step($urandom_range(0, 7) != 0, w, $urandom, $urandom, $urandom,
           $urandom_range(0, 1) == 1, rr(), $urandom);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
  end

  initial begin
    wait (done);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule